// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits inside a byte-wide NOR flash and turns the host's bus writes into operations. The host writes short command sequences, each opened by a fixed two-write unlock pattern. The decoder tracks where it is in each sequence and issues a one-cycle request to start a byte program or an erase. It also keeps the mask of sectors selected for erasure and reports its current mode to the status logic. The array, the charge pumps and the embedded algorithms are outside the block. They report completion through `op_done`.

A sector erase does not start at once. Its last write opens an acceptance window during which more sectors can be added. An erase that is running can be suspended. The host can then program sectors that are not being erased, or read the protection codes. A resume write continues the erase. Program or erase requests aimed at a protected sector are dropped without any indication. Any write that arrives while an operation is busy and is not meaningful at that point is also dropped.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), `sect_mask` is 0, and `prog_go`, `erase_go` and `asel_vld` are low.
- R2: A bus write takes effect only while `bus_cs_n`=0, `bus_we_n`=0 and `bus_oe_n`=1. The address is latched when that condition starts and the data is taken when it ends. A write made with `bus_oe_n`=0 changes nothing.
- R3: Each command sequence opens with a write of 0xAA (mode 1) and then a write of 0x55 (mode 2). Any other data at an unlock or erase-setup step returns the decoder to its base mode: 12 while erase is suspended, 0 otherwise.
- R4: The writes 0xAA, 0x55, 0xA0 (mode 3) followed by one more write pulse `prog_go` for one cycle, with `op_addr`/`op_data` set from that last write. The decoder then holds mode 8 until `op_done`, after which it returns to its base mode.
- R5: The writes 0xAA, 0x55, 0x80, 0xAA, 0x55, 0x10 start a chip erase. This pulses `erase_go`, loads `sect_mask` with every unprotected sector and enters mode 9.
- R6: If the sixth write is instead 0x30, the decoder enters mode 7 (window) and sets the mask bit of the sector given by address bits [19:16]. Each further 0x30 write adds its sector and restarts the window. After WIN_CYC cycles with no write, `erase_go` pulses and the decoder enters mode 10.
- R7: In the window, a write of anything other than 0x30 or 0xB0 returns the decoder to mode 0 and clears `sect_mask`.
- R8: In modes 8 and 9 every write is ignored, including 0xB0. In mode 10, every write other than 0xB0 is ignored.
- R9: 0xB0 in the window suspends at once (mode 12). 0xB0 in mode 10 enters mode 11 for SUSP_CYC cycles and then mode 12. In mode 12, 0x30 resumes to mode 10. It pulses `erase_go` only if the erase had not yet been started. Further 0x30 writes are ignored.
- R10: 0xAA, 0x55, 0x90 enter mode 13 (autoselect). A read strobe there pulses `asel_vld` one cycle later. `asel_q` is 0x01 if the address has low byte 0x02 and its sector is protected, and 0x00 otherwise. A write of 0xF0 leaves mode 13 for the base mode.
- R11: In mode 12, autoselect and program are accepted and both return to mode 12. A program aimed at a sector in `sect_mask` is ignored.
- R12: A program, sector-erase or add-sector write whose sector (address bits [19:16]) has its `sect_prot` bit set is ignored.
- R13: `op_done` in mode 9 or 10 returns the decoder to mode 0 and clears `sect_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_cs_n | input | 1 | Synchronised chip select, active low |
| bus_we_n | input | 1 | Synchronised write enable, active low |
| bus_oe_n | input | 1 | Synchronised output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | 8 | Bus write data |
| rd_stb | input | 1 | One-cycle read strobe |
| sect_prot | input | 16 | Protect bit per sector |
| op_done | input | 1 | Embedded operation finished |
| mode | output | 4 | Current decoder mode code |
| sect_mask | output | 16 | Sectors selected for erase |
| prog_go | output | 1 | Byte program start pulse |
| op_addr | output | ADDR_W | Program address |
| op_data | output | 8 | Program data |
| erase_go | output | 1 | Erase start pulse |
| asel_q | output | 8 | Autoselect read data |
| asel_vld | output | 1 | Autoselect read data valid |

## Verification
The bench builds the decoder with WIN_CYC=40 and SUSP_CYC=8 in place of the millisecond and microsecond defaults. This lets it time the expiry of the acceptance window, and the end of suspend latency, to the exact cycle. It also lets a single run combine window restarts, suspend during the window, suspend during a running erase, resume, and autoselect and program nested inside suspend. Sector 2 is protected throughout, so the dropped requests in chip erase, sector erase, add-sector and program can all be seen at the ports.

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int ADDR_W    = 20,
  parameter int SECT_BITS = 4,
  parameter int WIN_CYC   = 5_000_000,
  parameter int SUSP_CYC  = 2_000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_cs_n,
  input  logic                      bus_we_n,
  input  logic                      bus_oe_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [7:0]                bus_data,
  input  logic                      rd_stb,
  input  logic [(1<<SECT_BITS)-1:0] sect_prot,
  input  logic                      op_done,
  output logic [3:0]                mode,
  output logic [(1<<SECT_BITS)-1:0] sect_mask,
  output logic                      prog_go,
  output logic [ADDR_W-1:0]         op_addr,
  output logic [7:0]                op_data,
  output logic                      erase_go,
  output logic [7:0]                asel_q,
  output logic                      asel_vld
);
  localparam int NSECT = 1 << SECT_BITS;
  localparam int MAXC  = (WIN_CYC > SUSP_CYC) ? WIN_CYC : SUSP_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    M_READ = 4'd0, M_UNLK1 = 4'd1, M_UNLK2 = 4'd2, M_PSET = 4'd3,
    M_ERS1 = 4'd4, M_ERS2 = 4'd5, M_ERS3 = 4'd6, M_WIN = 4'd7,
    M_PROG = 4'd8, M_CHIP = 4'd9, M_SECT = 4'd10, M_SPEND = 4'd11,
    M_SUSP = 4'd12, M_ASEL = 4'd13
  } mode_t;

  mode_t                st;
  logic                 wr_q, in_susp, ers_run;
  logic [ADDR_W-1:0]    alat;
  logic [CW-1:0]        cnt;

  wire                  wr_act = !bus_cs_n && !bus_we_n && bus_oe_n;
  wire                  wr_end = wr_q && !wr_act;
  wire [7:0]            d      = bus_data;
  wire [SECT_BITS-1:0]  sa     = alat[ADDR_W-1 -: SECT_BITS];
  wire [NSECT-1:0]      sa_hot = NSECT'(1) << sa;
  wire                  sa_prot = sect_prot[sa];
  wire                  sa_sel  = sect_mask[sa];
  wire                  all_prot = &sect_prot;
  wire [SECT_BITS-1:0]  rd_sect = bus_addr[ADDR_W-1 -: SECT_BITS];
  mode_t                base;

  assign base = in_susp ? M_SUSP : M_READ;
  assign mode = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      alat <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act && !wr_q) alat <= bus_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= M_READ;
      in_susp   <= 1'b0;
      ers_run   <= 1'b0;
      cnt       <= '0;
      sect_mask <= '0;
      prog_go   <= 1'b0;
      erase_go  <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      asel_q    <= '0;
      asel_vld  <= 1'b0;
    end else begin
      prog_go  <= 1'b0;
      erase_go <= 1'b0;
      asel_vld <= 1'b0;
      case (st)
        M_READ:  if (wr_end && d == 8'hAA) st <= M_UNLK1;
        M_UNLK1: if (wr_end) st <= (d == 8'h55) ? M_UNLK2 : base;
        M_UNLK2: if (wr_end) begin
          if (d == 8'hA0)                  st <= M_PSET;
          else if (d == 8'h90)             st <= M_ASEL;
          else if (d == 8'h80 && !in_susp) st <= M_ERS1;
          else                             st <= base;
        end
        M_PSET: if (wr_end) begin
          if (sa_prot || (in_susp && sa_sel)) st <= base;
          else begin
            st      <= M_PROG;
            prog_go <= 1'b1;
            op_addr <= alat;
            op_data <= d;
          end
        end
        M_ERS1: if (wr_end) st <= (d == 8'hAA) ? M_ERS2 : M_READ;
        M_ERS2: if (wr_end) st <= (d == 8'h55) ? M_ERS3 : M_READ;
        M_ERS3: if (wr_end) begin
          if (d == 8'h10 && !all_prot) begin
            st        <= M_CHIP;
            sect_mask <= ~sect_prot;
            erase_go  <= 1'b1;
          end else if (d == 8'h30 && !sa_prot) begin
            st        <= M_WIN;
            sect_mask <= sa_hot;
            cnt       <= CW'(WIN_CYC - 1);
          end else st <= M_READ;
        end
        M_WIN: begin
          if (wr_end) begin
            if (d == 8'h30) begin
              if (!sa_prot) begin
                sect_mask <= sect_mask | sa_hot;
                cnt       <= CW'(WIN_CYC - 1);
              end
            end else if (d == 8'hB0) begin
              st      <= M_SUSP;
              in_susp <= 1'b1;
            end else begin
              st        <= M_READ;
              sect_mask <= '0;
            end
          end else if (cnt == '0) begin
            st       <= M_SECT;
            erase_go <= 1'b1;
            ers_run  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        M_PROG: if (op_done) st <= base;
        M_CHIP: if (op_done) begin
          st        <= M_READ;
          sect_mask <= '0;
        end
        M_SECT: begin
          if (op_done) begin
            st        <= M_READ;
            sect_mask <= '0;
            ers_run   <= 1'b0;
          end else if (wr_end && d == 8'hB0) begin
            st  <= M_SPEND;
            cnt <= CW'(SUSP_CYC - 1);
          end
        end
        M_SPEND: begin
          if (cnt == '0) begin
            st      <= M_SUSP;
            in_susp <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        M_SUSP: if (wr_end) begin
          if (d == 8'hAA) st <= M_UNLK1;
          else if (d == 8'h30) begin
            st      <= M_SECT;
            in_susp <= 1'b0;
            if (!ers_run) begin
              erase_go <= 1'b1;
              ers_run  <= 1'b1;
            end
          end
        end
        M_ASEL: begin
          if (rd_stb) begin
            asel_vld <= 1'b1;
            asel_q   <= (bus_addr[7:0] == 8'h02) ? {7'd0, sect_prot[rd_sect]} : 8'h00;
          end
          if (wr_end && d == 8'hF0) st <= base;
        end
        default: st <= M_READ;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
  parameter int SECT_BITS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [(1<<SECT_BITS)-1:0] sect_prot,
  input logic                      op_done,
  input logic [3:0]                mode,
  input logic [(1<<SECT_BITS)-1:0] sect_mask,
  input logic                      prog_go,
  input logic [SECT_BITS-1:0]      op_sect,
  input logic                      erase_go,
  input logic [7:0]                asel_q,
  input logic                      asel_vld
);
  localparam int NSECT = 1 << SECT_BITS;

  p_read_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0) |-> (!prog_go && !erase_go && !asel_vld));

  p_prog_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> (mode == 4'd8 && !erase_go));

  p_prog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd8 && !op_done) |=> (mode == 4'd8));

  p_chip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd9 && !op_done) |=> (mode == 4'd9));

  p_prog_unprot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> ((($past(sect_prot) >> op_sect) & NSECT'(1)) == '0));

  p_erase_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (sect_mask != '0 && (sect_mask & $past(sect_prot)) == '0));

  p_spend_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd11) |=> (mode == 4'd11 || mode == 4'd12));

  p_asel_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    asel_vld |-> (asel_q <= 8'd1 && mode == 4'd13));
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.SECT_BITS(SECT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sect_prot(sect_prot), .op_done(op_done),
  .mode(mode), .sect_mask(sect_mask), .prog_go(prog_go),
  .op_sect(op_addr[ADDR_W-1 -: SECT_BITS]), .erase_go(erase_go),
  .asel_q(asel_q), .asel_vld(asel_vld)
);

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 40;
  localparam int SUSP = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_cs_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        rd_stb = 1'b0, op_done = 1'b0;
  logic [15:0] sect_prot = 16'h0004;
  logic [3:0]  mode;
  logic [15:0] sect_mask;
  logic        prog_go, erase_go, asel_vld;
  logic [19:0] op_addr;
  logic [7:0]  op_data, asel_q;

  int checks = 0, fails = 0;

  typedef struct {
    int          kind;
    logic [19:0] a;
    logic [7:0]  d;
    logic [15:0] m;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(20), .SECT_BITS(4), .WIN_CYC(WIN), .SUSP_CYC(SUSP)) u_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .rd_stb(rd_stb), .sect_prot(sect_prot),
    .op_done(op_done), .mode(mode), .sect_mask(sect_mask), .prog_go(prog_go),
    .op_addr(op_addr), .op_data(op_data), .erase_go(erase_go), .asel_q(asel_q), .asel_vld(asel_vld)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [19:0] a, input logic [7:0] d,
                      input logic [15:0] m, input string tag);
    exp_t e;
    e.kind = k; e.a = a; e.d = d; e.m = m; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare every produced pulse against the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      k = prog_go ? 1 : erase_go ? 2 : asel_vld ? 3 : 0;
      if (k != 0) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R12 unexpected event actual=kind%0d expected=none", k);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.kind != k) begin
            fails++;
            $display("FAIL %s event kind actual=%0d expected=%0d", e.tag, k, e.kind);
          end else if (k == 1 && (op_addr != e.a || op_data != e.d)) begin
            fails++;
            $display("FAIL %s program actual=%h/%h expected=%h/%h", e.tag, op_addr, op_data, e.a, e.d);
          end else if (k == 2 && sect_mask != e.m) begin
            fails++;
            $display("FAIL %s erase mask actual=%h expected=%h", e.tag, sect_mask, e.m);
          end else if (k == 3 && asel_q != e.d) begin
            fails++;
            $display("FAIL %s autoselect actual=%h expected=%h", e.tag, asel_q, e.d);
          end
        end
      end
    end
  end

  task automatic bwrite2(input logic [19:0] a1, input logic [7:0] d1,
                         input logic [19:0] a2, input logic [7:0] d2, input logic oe_bad);
    @(negedge clk); bus_addr = a1; bus_data = d1; bus_oe_n = !oe_bad; bus_cs_n = 1'b0; bus_we_n = 1'b0;
    @(negedge clk); bus_addr = a2; bus_data = d2;
    @(negedge clk); bus_we_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1; bus_oe_n = 1'b0;
  endtask

  task automatic bwrite(input logic [19:0] a, input logic [7:0] d);
    bwrite2(a, d, a, d, 1'b0);
  endtask

  task automatic unlock();
    bwrite(20'h0, 8'hAA);
    bwrite(20'h0, 8'h55);
  endtask

  task automatic erase_setup();
    unlock(); bwrite(20'h0, 8'h80); unlock();
  endtask

  task automatic rd(input logic [19:0] a);
    @(negedge clk); bus_addr = a; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic done();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", mode, 0, "reset mode");
    chk("R1", sect_mask, 0, "reset mask");
    chk("R1", {prog_go, erase_go, asel_vld}, 0, "reset pulses");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R4: program, address from write start, data from write end
    push(1, 20'h12345, 8'h5A, '0, "R2");
    unlock(); bwrite(20'h0, 8'hA0);
    chk("R4", mode, 3, "program setup");
    bwrite2(20'h12345, 8'h11, 20'h77777, 8'h5A, 1'b0);
    chk("R4", mode, 8, "programming");
    bwrite(20'h0, 8'hB0);
    chk("R8", mode, 8, "suspend ignored in program");
    unlock();
    chk("R8", mode, 8, "writes ignored in program");
    done();
    chk("R4", mode, 0, "program done");

    // R2/R3
    bwrite2(20'h0, 8'hAA, 20'h0, 8'hAA, 1'b1);
    chk("R2", mode, 0, "write with oe low");
    bwrite(20'h0, 8'hAA);
    chk("R3", mode, 1, "first unlock");
    bwrite(20'h0, 8'h12);
    chk("R3", mode, 0, "bad second unlock");

    // R12: program to protected sector
    unlock(); bwrite(20'h0, 8'hA0); bwrite(20'h20040, 8'h77);
    chk("R12", mode, 0, "protected program");

    // R5: chip erase
    push(2, '0, '0, 16'hFFFB, "R5");
    erase_setup(); bwrite(20'h0, 8'h10);
    chk("R5", mode, 9, "chip erase");
    chk("R5", sect_mask, 16'hFFFB, "chip mask");
    bwrite(20'h0, 8'hB0);
    chk("R8", mode, 9, "suspend ignored in chip erase");
    done();
    chk("R13", mode, 0, "chip done");
    chk("R13", sect_mask, 0, "chip mask cleared");

    // R6: window, add sectors, exact expiry
    erase_setup(); bwrite(20'h50000, 8'h30);
    chk("R6", mode, 7, "window");
    chk("R6", sect_mask, 16'h0020, "first sector");
    bwrite(20'h20000, 8'h30);
    chk("R12", sect_mask, 16'h0020, "protected add");
    push(2, '0, '0, 16'h0220, "R6");
    bwrite(20'h91234, 8'h30);
    chk("R6", sect_mask, 16'h0220, "added sector");
    repeat (WIN - 1) @(negedge clk);
    chk("R6", mode, 7, "window last cycle");
    @(negedge clk);
    chk("R6", mode, 10, "erase started");

    // R8/R9: suspend with latency
    bwrite(20'h0, 8'hAA);
    chk("R8", mode, 10, "write ignored in erase");
    bwrite(20'h0, 8'hB0);
    chk("R9", mode, 11, "suspend pending");
    repeat (SUSP - 1) @(negedge clk);
    chk("R9", mode, 11, "pending last cycle");
    @(negedge clk);
    chk("R9", mode, 12, "suspended");

    // R11/R10: autoselect inside suspend
    unlock(); bwrite(20'h0, 8'h90);
    chk("R11", mode, 13, "autoselect from suspend");
    push(3, '0, 8'h01, '0, "R10"); rd(20'h20002);
    push(3, '0, 8'h00, '0, "R10"); rd(20'h50002);
    push(3, '0, 8'h00, '0, "R10"); rd(20'h20000);
    bwrite(20'h0, 8'hF0);
    chk("R11", mode, 12, "back to suspend");

    // R11: program in suspend
    unlock(); bwrite(20'h0, 8'hA0); bwrite(20'h90010, 8'h33);
    chk("R11", mode, 12, "program to erasing sector ignored");
    push(1, 20'h10010, 8'h33, '0, "R11");
    unlock(); bwrite(20'h0, 8'hA0); bwrite(20'h10010, 8'h33);
    chk("R11", mode, 8, "program in suspend");
    done();
    chk("R11", mode, 12, "program returns to suspend");
    chk("R11", sect_mask, 16'h0220, "mask kept");

    // R9: resume, second resume ignored
    bwrite(20'h0, 8'h30);
    chk("R9", mode, 10, "resumed");
    bwrite(20'h0, 8'h30);
    chk("R9", mode, 10, "second resume ignored");
    done();
    chk("R13", mode, 0, "sector erase done");
    chk("R13", sect_mask, 0, "sector mask cleared");

    // R9: suspend inside window, resume starts erase
    erase_setup(); bwrite(20'h30000, 8'h30);
    bwrite(20'h0, 8'hB0);
    chk("R9", mode, 12, "window suspend immediate");
    push(2, '0, '0, 16'h0008, "R9");
    bwrite(20'h0, 8'h30);
    chk("R9", mode, 10, "resume from window suspend");
    done();
    chk("R13", mode, 0, "done after resume");

    // R7: window abort
    erase_setup(); bwrite(20'h40000, 8'h30);
    bwrite(20'h0, 8'h90);
    chk("R7", mode, 0, "window abort");
    chk("R7", sect_mask, 0, "abort clears mask");

    // R3: mismatch in erase setup
    unlock(); bwrite(20'h0, 8'h80); bwrite(20'h0, 8'hAA); bwrite(20'h0, 8'h12);
    chk("R3", mode, 0, "bad erase unlock");

    // R12: sector erase on protected sector
    erase_setup(); bwrite(20'h20000, 8'h30);
    chk("R12", mode, 0, "protected sector erase");

    // R10: autoselect from read
    unlock(); bwrite(20'h0, 8'h90);
    chk("R10", mode, 13, "autoselect");
    push(3, '0, 8'h01, '0, "R10"); rd(20'h20002);
    bwrite(20'h0, 8'hF0);
    chk("R10", mode, 0, "autoselect exit");

    repeat (4) @(negedge clk);
    chk("R4", sb.size(), 0, "events outstanding");
    summary();
  end
endmodule